// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is the station side of a two-wire PHY management bus. It turns a single command register into complete management frames: software writes a start flag, a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of data. The block then divides the system clock down to the bus clock and shifts the frame out on the data line. When the frame ends it clears the start flag. After a read it leaves the returned data and an acknowledge flag in the same register.

When no command is waiting and the block is enabled, it keeps reading the basic status register (register 1) of every PHY address in turn. From each of these poll frames it keeps two 32-bit maps: which addresses answered, and which report link up. One address chosen by software is watched. A change of its link bit raises a sticky flag that software clears by writing a one to it.

The register bank is reached through a plain single-cycle write strobe and an address-selected read word. The bus data line is given as separate output, output-enable and input pins, so the pad and pull-up sit outside the block.

Top module: `mdio_mgmt`

## Requirements
- R1: After reset all five registers read 0, the bus clock is low and the data line is not driven.
- R2: Inside a frame the bus clock has a period of 2×(DIV+1) system clocks. It is low between frames and in the cycle after a frame ends.
- R3: A frame is 64 bits, most significant bit first: 32 ones, start bits 0 then 1, and an operation code. The code is 1 then 0 for a read and 0 then 1 for a write. Then come the 5-bit PHY address, the 5-bit register address, two turnaround bits (driven 1 then 0 on a write) and 16 data bits.
- R4: The driven data bit changes only while the bus clock is low, at its falling edge. Input bits are taken at the rising edge.
- R5: On a read the line is released from the first turnaround bit to the end of the frame. ACK (command bit 29) becomes 1 exactly when the line was 0 in the second turnaround bit. The 16 sampled bits land in command bits 15:0.
- R6: Command register (address 1): bit 31 start, bit 30 write, bit 29 ACK, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. Start reads 1 from the write until the frame is complete, then reads 0.
- R7: A write to the command register while start reads 1 is ignored.
- R8: Control register (address 0): bit 31 enable, bits 20:16 watched PHY address, bits 7:0 divider DIV. While enable is 0 no new frame begins.
- R9: While no command waits, poll frames read register 1 of addresses 0, 1, 2 … 31 and then wrap. A pending command is sent as the very next frame, so it completes within two frame times.
- R10: Address 2 bit n holds the ACK of the latest poll of address n. Address 3 bit n holds that ACK ANDed with bit 2 of the returned status.
- R11: Address 4 bit 0 is set when a poll of the watched address changes its link bit. Writing 1 to it clears it, writing 0 has no effect, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for read and write |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management bus clock |
| mdioOut | output | 1 | Data bit driven toward the bus |
| mdioOe | output | 1 | High while the block drives the data line |
| mdioIn | input | 1 | Resolved level of the data line |

## Verification
A frame takes 64 bus-clock periods, or 128×(DIV+1) system clocks, plus one launch cycle. A command result is therefore due within two such frames of the write. The maps and the link flag change on the falling edge that ends a poll frame. The bench never waits a fixed number of cycles for these. It polls the start bit through the register port, or waits for a count of completed frames seen by its PHY model on the bus. Every sample is taken at the falling system-clock edge, and the only fixed-time check is the bound of two frame times on a command.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int PRE_LEN   = 32;
  localparam int TA_POS    = 46;   // first turnaround bit index
  localparam int DATA_POS  = 48;   // first data bit index
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int LINK_BIT  = 2;
  localparam logic [4:0] STATUS_REG = 5'd1;

  localparam logic [2:0] A_CTRL    = 3'd0;
  localparam logic [2:0] A_CMD     = 3'd1;
  localparam logic [2:0] A_PRESENT = 3'd2;
  localparam logic [2:0] A_LINK    = 3'd3;
  localparam logic [2:0] A_EVENT   = 3'd4;

  typedef struct packed {
    logic load;
    logic shift;
    logic sampleAck;
    logic sampleData;
  } strobe_t;

  typedef struct packed {
    logic        isRead;
    logic [4:0]  phy;
    logic [4:0]  regNum;
    logic [15:0] data;
  } req_t;
endpackage

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic             isRead,
  input  logic [DIV_W-1:0] divVal,
  output strobe_t          stb,
  output logic             mdc,
  output logic             mdioOe,
  output logic             frameDone
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] ACK_IDX  = IDX_W'(TA_POS + 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_POS);

  logic             running, readFrame;
  logic [DIV_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;
  logic             halfEnd, riseNow, fallNow;

  assign halfEnd = running && (cnt >= divVal);
  assign riseNow = halfEnd && !mdc;
  assign fallNow = halfEnd && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      readFrame <= 1'b0;
      cnt       <= '0;
      mdc       <= 1'b0;
      bitIdx    <= '0;
    end else if (launch && !running) begin
      running   <= 1'b1;
      readFrame <= isRead;
      cnt       <= '0;
      mdc       <= 1'b0;
      bitIdx    <= '0;
    end else if (running) begin
      if (halfEnd) begin
        cnt <= '0;
        mdc <= !mdc;
        if (fallNow) begin
          if (bitIdx == LAST_IDX) running <= 1'b0;
          else                    bitIdx  <= bitIdx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign frameDone = fallNow && (bitIdx == LAST_IDX);
  assign mdioOe    = running && (!readFrame || (bitIdx < TA_IDX));

  always_comb begin
    stb.load       = launch && !running;
    stb.shift      = fallNow && (bitIdx != LAST_IDX);
    stb.sampleAck  = riseNow && readFrame && (bitIdx == ACK_IDX);
    stb.sampleData = riseNow && readFrame && (bitIdx >= DAT_IDX);
  end

  // R9: the scheduler only launches into an idle engine
  p_launch_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> !running);
  // R2: after the last falling edge the bus is quiet
  p_frame_end_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> (!mdc && !mdioOe));
endmodule

// File: rtl/mdio_dp.sv
`timescale 1ns/1ps
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  req_t        req,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic [15:0] rdData,
  output logic        ackBit
);
  logic [FRAME_LEN-1:0] outShift;
  logic [FRAME_LEN-1:0] frameWord;

  always_comb begin
    frameWord = {{PRE_LEN{1'b1}}, 2'b01,
                 (req.isRead ? 2'b10 : 2'b01),
                 req.phy, req.regNum,
                 (req.isRead ? 2'b11 : 2'b10),
                 req.data};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
      rdData   <= '0;
      ackBit   <= 1'b0;
    end else begin
      if (stb.load)            outShift <= frameWord;
      else if (stb.shift)      outShift <= {outShift[FRAME_LEN-2:0], 1'b1};
      if (stb.load)            ackBit   <= 1'b0;
      else if (stb.sampleAck)  ackBit   <= !mdioIn;
      if (stb.sampleData)      rdData   <= {rdData[14:0], mdioIn};
    end
  end

  assign mdioOut = outShift[FRAME_LEN-1];
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int N_PHY = 32,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             frameDone,
  input  logic [15:0]      rdData,
  input  logic             ackBit,
  output logic             launch,
  output req_t             req,
  output logic [DIV_W-1:0] divVal
);
  localparam int PA_W = (N_PHY > 1) ? $clog2(N_PHY) : 1;
  localparam logic [PA_W-1:0] LAST_PA = PA_W'(N_PHY - 1);

  logic             ctrlEnable;
  logic [4:0]       monAddr;
  logic [DIV_W-1:0] divReg;
  logic             cmdStart, cmdWrite, cmdAck;
  logic [4:0]       cmdPhy, cmdReg;
  logic [15:0]      cmdData;
  logic [N_PHY-1:0] presentMap, linkMap, hitVec;
  logic             linkEvt;
  logic [PA_W-1:0]  pollAddr;
  logic             inFlight, flightUser;
  logic             pollDone, userDone, newLink, monHit, evtSet, cmdWe;

  assign launch     = ctrlEnable && !inFlight;
  assign divVal     = divReg;
  assign req.isRead = cmdStart ? !cmdWrite : 1'b1;
  assign req.phy    = cmdStart ? cmdPhy : 5'(pollAddr);
  assign req.regNum = cmdStart ? cmdReg : STATUS_REG;
  assign req.data   = cmdData;

  assign pollDone = frameDone && inFlight && !flightUser;
  assign userDone = frameDone && inFlight && flightUser;
  assign newLink  = ackBit & rdData[LINK_BIT];
  assign monHit   = (5'(pollAddr) == monAddr);
  assign evtSet   = pollDone && monHit && (linkMap[pollAddr] != newLink);
  assign cmdWe    = regWr && (regAddr == A_CMD) && !cmdStart;

  for (genvar n = 0; n < N_PHY; n++) begin : g_hit
    assign hitVec[n] = pollDone && (pollAddr == PA_W'(n));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEnable <= 1'b0;
      monAddr    <= '0;
      divReg     <= '0;
    end else if (regWr && (regAddr == A_CTRL)) begin
      ctrlEnable <= regWdata[31];
      monAddr    <= regWdata[20:16];
      divReg     <= regWdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight   <= 1'b0;
      flightUser <= 1'b0;
    end else if (launch) begin
      inFlight   <= 1'b1;
      flightUser <= cmdStart;
    end else if (frameDone) begin
      inFlight   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdStart <= 1'b0;
      cmdWrite <= 1'b0;
      cmdAck   <= 1'b0;
      cmdPhy   <= '0;
      cmdReg   <= '0;
      cmdData  <= '0;
    end else if (cmdWe) begin
      cmdStart <= regWdata[31];
      cmdWrite <= regWdata[30];
      cmdAck   <= 1'b0;
      cmdPhy   <= regWdata[25:21];
      cmdReg   <= regWdata[20:16];
      cmdData  <= regWdata[15:0];
    end else if (userDone) begin
      cmdStart <= 1'b0;
      if (!cmdWrite) begin
        cmdData <= rdData;
        cmdAck  <= ackBit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollAddr   <= '0;
      presentMap <= '0;
      linkMap    <= '0;
      linkEvt    <= 1'b0;
    end else begin
      if (pollDone) pollAddr <= (pollAddr == LAST_PA) ? '0 : pollAddr + 1'b1;
      presentMap <= (presentMap & ~hitVec) | (hitVec & {N_PHY{ackBit}});
      linkMap    <= (linkMap & ~hitVec) | (hitVec & {N_PHY{newLink}});
      if (evtSet) linkEvt <= 1'b1;
      else if (regWr && (regAddr == A_EVENT) && regWdata[0]) linkEvt <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL: begin
        regRdata[31]          = ctrlEnable;
        regRdata[20:16]       = monAddr;
        regRdata[DIV_W-1:0]   = divReg;
      end
      A_CMD:     regRdata = {cmdStart, cmdWrite, cmdAck, 3'b000, cmdPhy, cmdReg, cmdData};
      A_PRESENT: regRdata[N_PHY-1:0] = presentMap;
      A_LINK:    regRdata[N_PHY-1:0] = linkMap;
      A_EVENT:   regRdata[0] = linkEvt;
      default:   regRdata = '0;
    endcase
  end

  // R6: start stays set until its own frame completes
  p_start_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !userDone) |=> cmdStart);
  // R11: the link flag only rises at the end of a poll frame
  p_evt_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkEvt) |-> $past(pollDone));
  // R9: every finished poll moves on to another address
  p_poll_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    pollDone |=> (pollAddr != $past(pollAddr)));
endmodule

// File: rtl/mdio_mgmt.sv
`timescale 1ns/1ps
module mdio_mgmt
  import mdio_pkg::*;
#(
  parameter int N_PHY = 32,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  strobe_t          stb;
  req_t             req;
  logic             launch, frameDone, ackBit;
  logic [15:0]      rdData;
  logic [DIV_W-1:0] divVal;

  mdio_regs #(.N_PHY(N_PHY), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .frameDone(frameDone),
    .rdData(rdData), .ackBit(ackBit), .launch(launch), .req(req),
    .divVal(divVal));

  mdio_ctrl #(.DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .launch(launch), .isRead(req.isRead),
    .divVal(divVal), .stb(stb), .mdc(mdc), .mdioOe(mdioOe),
    .frameDone(frameDone));

  mdio_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .req(req), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .rdData(rdData), .ackBit(ackBit));

  // R4: the driven bit holds steady while the bus clock is high
  p_out_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut));
endmodule

// File: tb/mdio_mgmt_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        mdc, mdioOut, mdioOe;
  logic        phyEn = 1'b0, phyVal = 1'b1;
  wire         mdioBus = mdioOe ? mdioOut : (phyEn ? phyVal : 1'b1);

  mdio_mgmt dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioBus));

  always #10 clk = !clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // PHY model state
  logic [31:0] presentMask = 32'h8000_0029;
  logic [31:0] linkMask    = 32'h0000_0028;
  logic [15:0] mem [0:31][0:31];
  int          frameCount = 0, riseCount = 0, lastPre = 0, outMoves = 0;
  longint      lastPeriod = 0, prevRiseT = 0;
  logic [1:0]  lastOp, lastTa;
  logic [4:0]  lastPhy, lastReg;
  logic        lastRel;
  logic [4:0]  seqPhy [0:7];

  initial begin
    int ones, pos;
    logic b, rel;
    logic [1:0] op, ta;
    logic [4:0] pa, ra;
    logic [15:0] wd, rv;
    ones = 0; pos = -1; rel = 1'b1; op = '0; ta = '0; pa = '0; ra = '0; wd = '0; rv = '0;
    for (int p = 0; p < 32; p++) for (int r = 0; r < 32; r++) mem[p][r] = '0;
    forever begin
      @(posedge mdc);
      riseCount++;
      b = mdioBus;
      if (pos >= 0) lastPeriod = ($time - prevRiseT) / 20;
      prevRiseT = $time;
      if (pos < 0) begin
        if (b) ones++;
        else begin
          lastPre = ones;
          if (ones >= 32) pos = 0;
          ones = 0;
        end
      end else begin
        pos++;
        if (pos == 2 || pos == 3) op = {op[0], b};
        if (pos >= 4 && pos <= 8) pa = {pa[3:0], b};
        if (pos >= 9 && pos <= 13) ra = {ra[3:0], b};
        if (pos == 13) begin
          rel = 1'b1;
          rv = (ra == 5'd1) ? (16'h7809 | {13'b0, linkMask[pa], 2'b00}) : mem[pa][ra];
        end
        if (pos >= 14 && op == 2'b10 && mdioOe) rel = 1'b0;
        if (pos == 14 || pos == 15) ta = {ta[0], b};
        if (pos >= 16 && op == 2'b01) wd = {wd[14:0], b};
        if (op == 2'b10 && presentMask[pa]) begin
          if (pos == 14) begin phyEn = 1'b1; phyVal = 1'b0; end
          if (pos >= 15 && pos <= 30) phyVal = rv[30-pos];
        end
        if (pos == 31) begin
          phyEn = 1'b0;
          if (op == 2'b01 && presentMask[pa]) mem[pa][ra] = wd;
          lastOp = op; lastPhy = pa; lastReg = ra; lastTa = ta; lastRel = rel;
          if (frameCount < 8) seqPhy[frameCount] = pa;
          frameCount++;
          pos = -1; ones = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(mdioOut);
      #1;
      if (mdc) outMoves++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic waitCmd(output int cyc);
    logic [31:0] v;
    cyc = 0;
    do begin regRead(3'd1, v); cyc++; end while (v[31]);
  endtask

  task automatic waitFrames(input int n);
    int target;
    target = frameCount + n;
    while (frameCount < target) @(negedge clk);
  endtask

  function automatic logic [31:0] cmdWord(input bit wr, input logic [4:0] p,
                                          input logic [4:0] r, input logic [15:0] d);
    return {1'b1, wr, 1'b0, 3'b000, p, r, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      check(v == 32'h0, "R1", "register after reset", v, 0);
    end
    check(!mdc && !mdioOe, "R1", "bus idle after reset", {mdc, mdioOe}, 0);

    // R8: disabled block starts no frame
    repeat (300) @(negedge clk);
    check(riseCount == 0, "R8", "clock edges while disabled", riseCount, 0);

    // enable, watch address 5, divider 0
    regWrite(3'd0, 32'h8005_0000);
    regRead(3'd0, v);
    check(v == 32'h8005_0000, "R8", "control readback", v, 32'h8005_0000);
    waitFrames(4);
    for (int i = 0; i < 4; i++)
      check(seqPhy[i] == 5'(i), "R9", "poll order", seqPhy[i], i);
    check(lastOp == 2'b10 && lastReg == 5'd1, "R3", "poll is a read of register 1",
          {lastOp, lastReg}, {2'b10, 5'd1});
    check(lastPre == 32, "R3", "preamble length", lastPre, 32);
    check(lastPeriod == 2, "R2", "bus clock period at DIV 0", lastPeriod, 2);
    check(lastRel == 1'b1, "R5", "line released on read", lastRel, 1);

    // R10/R11: a full sweep
    waitFrames(34);
    regRead(3'd2, v);
    check(v == presentMask, "R10", "present map", v, presentMask);
    regRead(3'd3, v);
    check(v == (presentMask & linkMask), "R10", "link map", v, presentMask & linkMask);
    regRead(3'd4, v);
    check(v == 32'h1, "R11", "flag after watched link rose", v, 1);
    regWrite(3'd4, 32'h0);
    regRead(3'd4, v);
    check(v == 32'h1, "R11", "writing 0 keeps flag", v, 1);
    regWrite(3'd4, 32'h1);
    regRead(3'd4, v);
    check(v == 32'h0, "R11", "writing 1 clears flag", v, 0);

    // R6/R7/R3: user write
    regWrite(3'd1, cmdWord(1'b1, 5'd3, 5'd4, 16'hA5C3));
    regWrite(3'd1, cmdWord(1'b1, 5'd6, 5'd9, 16'h1111));
    regRead(3'd1, v);
    check(v[31] == 1'b1, "R6", "start reads 1 while pending", v[31], 1);
    check(v[25:0] == {5'd3, 5'd4, 16'hA5C3}, "R7", "busy write ignored",
          v[25:0], {5'd3, 5'd4, 16'hA5C3});
    waitCmd(cyc);
    check(cyc >= 100 && cyc <= 275, "R9", "command done within two frames", cyc, 275);
    check(mem[3][4] == 16'hA5C3, "R3", "PHY received write data", mem[3][4], 16'hA5C3);
    check(lastOp == 2'b01 && lastTa == 2'b10, "R3", "write code and turnaround",
          {lastOp, lastTa}, {2'b01, 2'b10});
    check(mem[6][9] == 16'h0, "R7", "rejected command not sent", mem[6][9], 0);

    // R5: read back
    regWrite(3'd1, cmdWord(1'b0, 5'd3, 5'd4, 16'h0));
    waitCmd(cyc);
    regRead(3'd1, v);
    check(v[29] == 1'b1 && v[15:0] == 16'hA5C3, "R5", "read data and ACK",
          {v[29], v[15:0]}, {1'b1, 16'hA5C3});
    check(lastRel == 1'b1 && lastOp == 2'b10, "R5", "release during read", {lastRel, lastOp}, 3'b110);

    // R3/R5: sweep of write/read pairs on the edge addresses
    for (int k = 0; k < 6; k++) begin
      logic [4:0]  p;
      logic [15:0] d;
      p = (k % 2 == 1) ? 5'd31 : 5'd0;
      d = 16'((16'h1357 * (k + 1)) ^ 16'h8001);
      regWrite(3'd1, cmdWord(1'b1, p, 5'(8 + k), d));
      waitCmd(cyc);
      regWrite(3'd1, cmdWord(1'b0, p, 5'(8 + k), 16'h0));
      waitCmd(cyc);
      regRead(3'd1, v);
      check(v[29] == 1'b1 && v[15:0] == d, "R5", "sweep read back", {v[29], v[15:0]}, {1'b1, d});
    end

    // R5: absent PHY
    regWrite(3'd1, cmdWord(1'b0, 5'd7, 5'd4, 16'h0));
    waitCmd(cyc);
    regRead(3'd1, v);
    check(v[29] == 1'b0 && v[15:0] == 16'hFFFF, "R5", "absent PHY gives no ACK",
          {v[29], v[15:0]}, {1'b0, 16'hFFFF});

    // R11: watched link drops
    linkMask[5] = 1'b0;
    waitFrames(34);
    regRead(3'd4, v);
    check(v == 32'h1, "R11", "flag after watched link fell", v, 1);
    regRead(3'd3, v);
    check(v == 32'h8, "R10", "link map after drop", v, 32'h8);
    regWrite(3'd4, 32'h1);
    linkMask[3] = 1'b0;
    waitFrames(34);
    regRead(3'd4, v);
    check(v == 32'h0, "R11", "unwatched change leaves flag", v, 0);
    regRead(3'd3, v);
    check(v == 32'h0, "R10", "link map after second drop", v, 0);

    // R2: divider 3
    regWrite(3'd0, 32'h8005_0003);
    waitFrames(2);
    check(lastPeriod == 8, "R2", "bus clock period at DIV 3", lastPeriod, 8);

    // R8: disable
    regWrite(3'd0, 32'h0005_0003);
    repeat (600) @(negedge clk);
    cyc = frameCount;
    repeat (1200) @(negedge clk);
    check(frameCount == cyc && !mdc, "R8", "no frames after disable", frameCount, cyc);

    check(outMoves == 0, "R4", "output moves while clock high", outMoves, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule